// File: doc/BRIEF.md
# Decode-Resolved Pipeline Hazard and Redirect Controller

This block is the control point for a five-stage in-order pipeline that resolves every branch and jump while the instruction is still in decode. It compares the decode-stage source register indices with the destination index of the instructions in execute and memory. From that comparison it decides whether the front end must freeze for a cycle while a bubble is sent into execute. It also decides whether the instruction just fetched must be thrown away because decode has redirected the program counter.

Resolving in decode keeps the taken-branch penalty at one discarded instruction. The cost is extra stall cases: a jump or branch may need an operand that is still being computed in execute, or that a load in memory has not yet returned. The block also holds the fetch-to-decode pipeline register and applies the hold and clear actions to it directly. The program counter, the register file, the forwarding muxes and the execute stage sit outside and act on the stall and flush outputs.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the fetch-to-decode register holds the no-op word 0x00000013 and the entry address (parameter, default 0x00001000). With idle decode inputs, all four stall and flush outputs are low.
- R2: A stall is raised when the execute instruction is a load whose nonzero destination equals either decode source index.
- R3: A stall is raised when the memory-stage instruction is a load and decode holds a register-indirect jump whose source index equals that load's nonzero destination.
- R4: A stall is raised when decode holds a register-indirect jump whose source index equals the nonzero destination of a register-writing instruction in execute.
- R5: A stall is raised when decode holds a conditional branch and either source index equals the nonzero destination of a register-writing instruction in execute, or of a load in memory.
- R6: During a stall, pc_stall, ifid_stall and idex_flush are all high, and the fetch-to-decode register keeps its instruction and address across the clock edge.
- R7: ifid_flush is high when decode holds a taken conditional branch, a direct jump or a register-indirect jump. After the edge the register holds the no-op word and the entry address. A not-taken branch, or a taken flag without a branch, causes no flush.
- R8: When a stall and a redirect apply in the same cycle, the stall is raised and ifid_flush stays low.
- R9: Register index 0 as a destination never causes a stall.
- R10: A non-load result in memory, a load in memory seen by a non-jump non-branch instruction, and a non-load result in execute seen by a plain instruction cause no stall.
- R11: With neither stall nor flush, the register captures the fetched instruction and its address at every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs1 | input | 5 | Decode first source index |
| id_rs2 | input | 5 | Decode second source index |
| id_is_branch | input | 1 | Decode holds a conditional branch |
| id_is_jal | input | 1 | Decode holds a direct jump |
| id_is_jalr | input | 1 | Decode holds a register-indirect jump |
| id_br_taken | input | 1 | Branch condition evaluated true in decode |
| ex_rd | input | 5 | Execute destination index |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_reg_we | input | 1 | Execute instruction writes a register |
| mem_rd | input | 5 | Memory-stage destination index |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| fe_instr | input | 32 | Fetched instruction word |
| fe_pc | input | 32 | Address of fetched instruction |
| pc_stall | output | 1 | Hold the program counter |
| ifid_stall | output | 1 | Hold the fetch-to-decode register |
| ifid_flush | output | 1 | Clear the fetch-to-decode register |
| idex_flush | output | 1 | Clear execute control bits (bubble) |
| ifid_instr | output | 32 | Instruction presented to decode |
| ifid_pc | output | 32 | Address presented to decode |

## Verification
The hardest situation to reach is the one where a redirect and a stall coincide. A jump or taken branch sits in decode while its own operand, or a load-use dependency, is still in flight, so the flush must be dropped and the register held rather than cleared. The stimulus table puts a direct jump beside a matching load in execute and a taken branch beside a register-writing instruction in execute. A directed sequence then holds that combination across a clock edge and confirms that the register keeps the earlier instruction instead of taking the no-op.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   localparam int unsigned HZD_XLEN_DEF  = 32;
   localparam int unsigned HZD_IDX_W_DEF = 5;
   localparam logic [31:0] HZD_NOP_WORD  = 32'h0000_0013;
   localparam logic [31:0] HZD_ENTRY_DEF = 32'h0000_1000;

   // control-flow flags of the instruction sitting in decode
   typedef struct packed {
      logic is_branch;
      logic is_jal;
      logic is_jalr;
      logic taken;
   } hzd_flow_t;

endpackage

// File: rtl/hzd_stall_detect.sv
module hzd_stall_detect #(
   parameter int unsigned IDX_W        = 5,
   parameter bit          BRANCH_CHECK = 1'b1
) (
   input  logic [IDX_W-1:0] id_rs1,
   input  logic [IDX_W-1:0] id_rs2,
   input  hzd_pkg::hzd_flow_t flow,
   input  logic [IDX_W-1:0] ex_rd,
   input  logic             ex_is_load,
   input  logic             ex_reg_we,
   input  logic [IDX_W-1:0] mem_rd,
   input  logic             mem_is_load,
   output logic             stall
);

   if (IDX_W < 1) begin : g_bad_idx
      $error("IDX_W must be at least 1");
   end

   function automatic logic idx_hit(input logic [IDX_W-1:0] dst,
                                    input logic [IDX_W-1:0] src);
      return (dst != '0) && (dst == src);
   endfunction

   logic ex_hit1, ex_hit2, mem_hit1, mem_hit2;
   logic load_use, load_jump, alu_jump, branch_dep;

   always_comb begin
      ex_hit1  = idx_hit(ex_rd, id_rs1);
      ex_hit2  = idx_hit(ex_rd, id_rs2);
      mem_hit1 = idx_hit(mem_rd, id_rs1);
      mem_hit2 = idx_hit(mem_rd, id_rs2);
   end

   always_comb begin
      load_use  = ex_is_load && (ex_hit1 || ex_hit2);
      load_jump = mem_is_load && flow.is_jalr && mem_hit1;
      alu_jump  = ex_reg_we && flow.is_jalr && ex_hit1;
   end

   if (BRANCH_CHECK) begin : g_branch_chk
      always_comb begin
         branch_dep = flow.is_branch &&
                      ((ex_reg_we && (ex_hit1 || ex_hit2)) ||
                       (mem_is_load && (mem_hit1 || mem_hit2)));
      end
   end else begin : g_branch_nochk
      always_comb branch_dep = 1'b0;
   end

   assign stall = load_use || load_jump || alu_jump || branch_dep;

endmodule

// File: rtl/hzd_redirect.sv
module hzd_redirect (
   input  hzd_pkg::hzd_flow_t flow,
   input  logic               stall,
   output logic               flush
);

   logic redirect;

   always_comb begin
      redirect = (flow.is_branch && flow.taken) || flow.is_jal || flow.is_jalr;
      // operands are stale while stalled, so the redirect waits
      flush    = redirect && !stall;
   end

endmodule

// File: rtl/hzd_ifid_reg.sv
module hzd_ifid_reg #(
   parameter int unsigned XLEN      = 32,
   parameter logic [XLEN-1:0] NOP   = 32'h0000_0013,
   parameter logic [XLEN-1:0] ENTRY = 32'h0000_1000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold,
   input  logic            clear,
   input  logic [XLEN-1:0] d_instr,
   input  logic [XLEN-1:0] d_pc,
   output logic [XLEN-1:0] q_instr,
   output logic [XLEN-1:0] q_pc
);

   if (XLEN < 32) begin : g_bad_xlen
      $error("XLEN must be at least 32");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_instr <= NOP;
         q_pc    <= ENTRY;
      end else if (clear) begin
         q_instr <= NOP;
         q_pc    <= ENTRY;
      end else if (!hold) begin
         q_instr <= d_instr;
         q_pc    <= d_pc;
      end
   end

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
   parameter int unsigned XLEN         = hzd_pkg::HZD_XLEN_DEF,
   parameter int unsigned IDX_W        = hzd_pkg::HZD_IDX_W_DEF,
   parameter logic [XLEN-1:0] ENTRY    = hzd_pkg::HZD_ENTRY_DEF,
   parameter bit          BRANCH_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] id_rs1,
   input  logic [IDX_W-1:0] id_rs2,
   input  logic             id_is_branch,
   input  logic             id_is_jal,
   input  logic             id_is_jalr,
   input  logic             id_br_taken,
   input  logic [IDX_W-1:0] ex_rd,
   input  logic             ex_is_load,
   input  logic             ex_reg_we,
   input  logic [IDX_W-1:0] mem_rd,
   input  logic             mem_is_load,
   input  logic [XLEN-1:0]  fe_instr,
   input  logic [XLEN-1:0]  fe_pc,
   output logic             pc_stall,
   output logic             ifid_stall,
   output logic             ifid_flush,
   output logic             idex_flush,
   output logic [XLEN-1:0]  ifid_instr,
   output logic [XLEN-1:0]  ifid_pc
);

   localparam logic [XLEN-1:0] NOP_W = XLEN'(hzd_pkg::HZD_NOP_WORD);

   hzd_pkg::hzd_flow_t flow;
   logic stall_w, flush_w;

   assign flow = '{is_branch: id_is_branch, is_jal: id_is_jal,
                   is_jalr: id_is_jalr, taken: id_br_taken};

   hzd_stall_detect #(.IDX_W(IDX_W), .BRANCH_CHECK(BRANCH_CHECK)) u_stall (
      .id_rs1      (id_rs1),
      .id_rs2      (id_rs2),
      .flow        (flow),
      .ex_rd       (ex_rd),
      .ex_is_load  (ex_is_load),
      .ex_reg_we   (ex_reg_we),
      .mem_rd      (mem_rd),
      .mem_is_load (mem_is_load),
      .stall       (stall_w)
   );

   hzd_redirect u_redir (
      .flow  (flow),
      .stall (stall_w),
      .flush (flush_w)
   );

   hzd_ifid_reg #(.XLEN(XLEN), .NOP(NOP_W), .ENTRY(ENTRY)) u_ifid (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (stall_w),
      .clear   (flush_w),
      .d_instr (fe_instr),
      .d_pc    (fe_pc),
      .q_instr (ifid_instr),
      .q_pc    (ifid_pc)
   );

   assign pc_stall   = stall_w;
   assign ifid_stall = stall_w;
   assign idex_flush = stall_w;
   assign ifid_flush = flush_w;

endmodule

// File: rtl/hzd_checker.sv
module hzd_checker #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned IDX_W = 5,
   parameter logic [XLEN-1:0] ENTRY = 32'h0000_1000
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] id_rs1,
   input logic [IDX_W-1:0] ex_rd,
   input logic             ex_is_load,
   input logic             ex_reg_we,
   input logic [IDX_W-1:0] mem_rd,
   input logic             mem_is_load,
   input logic [XLEN-1:0]  fe_instr,
   input logic             pc_stall,
   input logic             ifid_stall,
   input logic             ifid_flush,
   input logic [XLEN-1:0]  ifid_instr,
   input logic [XLEN-1:0]  ifid_pc
);

   localparam logic [XLEN-1:0] NOP_W = XLEN'(hzd_pkg::HZD_NOP_WORD);

   // R2
   ld_use_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_is_load && ex_rd != '0 && ex_rd == id_rs1) |-> pc_stall);

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ifid_stall |=> ($stable(ifid_instr) && $stable(ifid_pc)));

   // R7
   flush_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ifid_flush |=> (ifid_instr == NOP_W && ifid_pc == ENTRY));

   // R8
   stall_beats_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ifid_flush && ifid_stall));

   // R9
   zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_rd == '0 && mem_rd == '0) |-> !pc_stall);

   // R10
   no_producer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ex_is_load && !ex_reg_we && !mem_is_load) |-> !pc_stall);

   // R11
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ifid_stall && !ifid_flush) |=> ifid_instr == $past(fe_instr));

endmodule

bind pipe_hazard_ctl hzd_checker #(.XLEN(XLEN), .IDX_W(IDX_W), .ENTRY(ENTRY)) u_hzd_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .id_rs1      (id_rs1),
   .ex_rd       (ex_rd),
   .ex_is_load  (ex_is_load),
   .ex_reg_we   (ex_reg_we),
   .mem_rd      (mem_rd),
   .mem_is_load (mem_is_load),
   .fe_instr    (fe_instr),
   .pc_stall    (pc_stall),
   .ifid_stall  (ifid_stall),
   .ifid_flush  (ifid_flush),
   .ifid_instr  (ifid_instr),
   .ifid_pc     (ifid_pc)
);

// File: tb/pipe_hazard_ctl_bench.sv
module pipe_hazard_ctl_bench;

   localparam logic [31:0] NOP   = 32'h0000_0013;
   localparam logic [31:0] ENTRY = 32'h0000_1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
   logic id_is_branch = 0, id_is_jal = 0, id_is_jalr = 0, id_br_taken = 0;
   logic ex_is_load = 0, ex_reg_we = 0, mem_is_load = 0;
   logic [31:0] fe_instr = '0, fe_pc = '0;
   logic pc_stall, ifid_stall, ifid_flush, idex_flush;
   logic [31:0] ifid_instr, ifid_pc;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   pipe_hazard_ctl u_pipe_hazard_ctl (
      .clk(clk), .rst_n(rst_n),
      .id_rs1(id_rs1), .id_rs2(id_rs2),
      .id_is_branch(id_is_branch), .id_is_jal(id_is_jal),
      .id_is_jalr(id_is_jalr), .id_br_taken(id_br_taken),
      .ex_rd(ex_rd), .ex_is_load(ex_is_load), .ex_reg_we(ex_reg_we),
      .mem_rd(mem_rd), .mem_is_load(mem_is_load),
      .fe_instr(fe_instr), .fe_pc(fe_pc),
      .pc_stall(pc_stall), .ifid_stall(ifid_stall),
      .ifid_flush(ifid_flush), .idex_flush(idex_flush),
      .ifid_instr(ifid_instr), .ifid_pc(ifid_pc)
   );

   // vector: rs1 rs2 br jal jalr taken exrd exld exwe memrd memld | stall flush
   localparam int NV = 17;
   localparam logic [28:0] VEC [NV] = '{
      {5'd0,5'd0, 1'b0,1'b0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 1'b0,1'b0}, // R10 idle
      {5'd3,5'd1, 1'b0,1'b0,1'b0,1'b0, 5'd3,1'b1,1'b1, 5'd0,1'b0, 1'b1,1'b0}, // R2 rs1
      {5'd1,5'd7, 1'b0,1'b0,1'b0,1'b0, 5'd7,1'b1,1'b1, 5'd0,1'b0, 1'b1,1'b0}, // R2 rs2
      {5'd0,5'd0, 1'b0,1'b0,1'b0,1'b0, 5'd0,1'b1,1'b1, 5'd0,1'b1, 1'b0,1'b0}, // R9 x0
      {5'd5,5'd1, 1'b0,1'b0,1'b0,1'b0, 5'd5,1'b0,1'b1, 5'd0,1'b0, 1'b0,1'b0}, // R10 alu in ex
      {5'd5,5'd1, 1'b0,1'b0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd5,1'b1, 1'b0,1'b0}, // R10 load in mem
      {5'd6,5'd0, 1'b0,1'b0,1'b1,1'b0, 5'd0,1'b0,1'b0, 5'd6,1'b1, 1'b1,1'b0}, // R3
      {5'd6,5'd0, 1'b0,1'b0,1'b1,1'b0, 5'd6,1'b0,1'b1, 5'd0,1'b0, 1'b1,1'b0}, // R4
      {5'd6,5'd0, 1'b0,1'b0,1'b1,1'b0, 5'd0,1'b0,1'b0, 5'd6,1'b0, 1'b0,1'b1}, // R10 alu in mem
      {5'd0,5'd0, 1'b0,1'b1,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 1'b0,1'b1}, // R7 jal
      {5'd2,5'd9, 1'b1,1'b0,1'b0,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 1'b0,1'b1}, // R7 taken
      {5'd2,5'd9, 1'b1,1'b0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 1'b0,1'b0}, // R7 not taken
      {5'd2,5'd9, 1'b1,1'b0,1'b0,1'b1, 5'd9,1'b0,1'b1, 5'd0,1'b0, 1'b1,1'b0}, // R5 ex alu
      {5'd2,5'd9, 1'b1,1'b0,1'b0,1'b1, 5'd0,1'b0,1'b0, 5'd2,1'b1, 1'b1,1'b0}, // R5 mem load
      {5'd0,5'd0, 1'b0,1'b0,1'b1,1'b0, 5'd0,1'b0,1'b1, 5'd0,1'b1, 1'b0,1'b1}, // R9 jalr x0
      {5'd0,5'd0, 1'b0,1'b0,1'b0,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 1'b0,1'b0}, // R7 stray taken
      {5'd4,5'd0, 1'b0,1'b1,1'b0,1'b0, 5'd4,1'b1,1'b1, 5'd0,1'b0, 1'b1,1'b0}  // R8 jal vs load
   };
   localparam int REQ [NV] = '{10,2,2,9,10,10,3,4,10,7,7,7,5,5,9,7,8};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      id_rs1 = 0; id_rs2 = 0; id_is_branch = 0; id_is_jal = 0; id_is_jalr = 0;
      id_br_taken = 0; ex_rd = 0; ex_is_load = 0; ex_reg_we = 0;
      mem_rd = 0; mem_is_load = 0;
   endtask

   task automatic apply(input logic [28:0] v);
      id_rs1 = v[28:24]; id_rs2 = v[23:19];
      id_is_branch = v[18]; id_is_jal = v[17]; id_is_jalr = v[16]; id_br_taken = v[15];
      ex_rd = v[14:10]; ex_is_load = v[9]; ex_reg_we = v[8];
      mem_rd = v[7:3]; mem_is_load = v[2];
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      idle();
      fe_instr = 32'h1111_0001; fe_pc = 32'h0000_0100;
      repeat (2) @(negedge clk);
      // R1 reset state
      chk("R1 instr", ifid_instr, NOP);
      chk("R1 pc", ifid_pc, ENTRY);
      chk("R1 outs", {28'd0, pc_stall, ifid_stall, ifid_flush, idex_flush}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 capture right after reset release
      chk("R11 first", ifid_instr, 32'h1111_0001);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(VEC[i]);
         fe_pc = 32'h200 + 32'(i * 4);
         #5;
         chk($sformatf("R%0d vec%0d stall", REQ[i], i), {31'd0, pc_stall}, {31'd0, VEC[i][1]});
         chk($sformatf("R%0d vec%0d flush", REQ[i], i), {31'd0, ifid_flush}, {31'd0, VEC[i][0]});
      end

      // R11 plain capture
      @(negedge clk); idle();
      fe_instr = 32'hA000_0001; fe_pc = 32'h0000_0300;
      @(negedge clk);
      chk("R11 instr", ifid_instr, 32'hA000_0001);
      chk("R11 pc", ifid_pc, 32'h0000_0300);

      // R6 stall holds register and raises all three stall outputs
      id_rs1 = 5'd3; ex_rd = 5'd3; ex_is_load = 1; ex_reg_we = 1;
      fe_instr = 32'hA000_0002; fe_pc = 32'h0000_0304;
      #5;
      chk("R6 outs", {29'd0, pc_stall, ifid_stall, idex_flush}, 32'd7);
      @(negedge clk);
      chk("R6 hold instr", ifid_instr, 32'hA000_0001);
      chk("R6 hold pc", ifid_pc, 32'h0000_0300);

      // R8 jump in decode during a stall: no flush, register held
      id_is_jal = 1;
      #5;
      chk("R8 flush low", {31'd0, ifid_flush}, 32'd0);
      @(negedge clk);
      chk("R8 held", ifid_instr, 32'hA000_0001);

      // R7 jump without stall clears register
      ex_is_load = 0; ex_reg_we = 0; ex_rd = 0;
      fe_instr = 32'hA000_0003; fe_pc = 32'h0000_0308;
      #5;
      chk("R7 flush", {31'd0, ifid_flush}, 32'd1);
      @(negedge clk);
      chk("R7 nop", ifid_instr, NOP);
      chk("R7 entry", ifid_pc, ENTRY);

      idle();
      fe_instr = 32'hA000_0004; fe_pc = 32'h0000_0400;
      @(negedge clk);
      chk("R11 after flush", ifid_instr, 32'hA000_0004);

      // R1 reset in mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 rerst instr", ifid_instr, NOP);
      chk("R1 rerst pc", ifid_pc, ENTRY);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule